// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block derives a transmit baud clock from a fixed serial reference clock (nominally about 1.85 MHz) by a programmable 16-bit ratio N. One baud period lasts N reference cycles. One baud period is also one period of the receive sample clock. For N of 3 or more, the waveform is not a plain divide-by-N square wave. Each period opens with a low phase of exactly two reference cycles, and the output stays high for the other N-2 cycles. The two smallest ratios have their own shapes. N=2 gives one cycle low and one cycle high. N=1 passes the reference clock straight through, so the output is low for half a cycle and high for half a cycle.

Software-side logic writes a new ratio by presenting it on the divisor input together with a one-cycle load strobe. The value is held in a shadow register. It replaces the running ratio only at the next period boundary, so a period that has already started is never shortened or stretched. A ratio of 0 parks the generator: the baud clock stays low and no ticks are produced until a non-zero ratio is loaded. A one-cycle tick output marks the first reference cycle of each low phase, which lets a downstream shifter advance without detecting edges itself.

Top module: `baud_clock_gen`

## Requirements
- R1: While reset is asserted and after it is released, the generator is parked: `baud_clk` is 0 and `baud_tick` is 0 until a non-zero divisor is loaded.
- R2: A divisor captured by `div_load` takes effect at the first period boundary after the load. The period in progress runs to its full old length. When the generator is parked or running at N=1, the new divisor starts with the reference edge that follows the capturing edge.
- R3: For N >= 3, every baud period lasts N reference cycles. `baud_clk` is 0 for the first 2 cycles and 1 for the remaining N-2 cycles.
- R4: For N = 2, `baud_clk` is 0 for one reference cycle and 1 for the next, and this repeats.
- R5: For N = 1, `baud_clk` equals the reference clock (high in its first half, low in its second half) and `baud_tick` stays at 1.
- R6: For N >= 2, `baud_tick` is 1 for exactly the first reference cycle of each period, which is the first cycle of the low phase. It is 0 in all other cycles.
- R7: Loading a divisor of 0 parks the generator from the next period boundary. While parked, `baud_clk` is 0 and `baud_tick` is 0.
- R8: If several loads arrive within one period, the last value captured before the boundary is the one applied.
- R9: For N >= 2, `baud_clk` changes only on a rising reference edge, because it is driven by a flip-flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Serial reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_value | input | 16 | Division ratio N to capture (0 = park) |
| div_load | input | 1 | One-cycle strobe that captures `div_value` |
| baud_clk | output | 1 | Shaped baud clock |
| baud_tick | output | 1 | One-cycle pulse at the start of each low phase |

## Verification
The hardest case to reach from the ports is a reload that arrives in the middle of a period. The bench must show that the old period still completes at its full length, and that only the last of several back-to-back loads takes effect. To reach it, the bench first parks the generator so that the reload timing is known exactly. It then starts a long period and counts reference cycles from the first tick. Loads are placed at chosen phases inside that period, and the bench checks the waveform cycle by cycle across the boundary. A sweep over many ratios, a ratio of 1, the largest ratio and a ratio of 0 complete the checks.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Number of reference cycles the output spends low in one period.
  function automatic int unsigned low_cycles(input int unsigned n);
    return (n == 32'd2) ? 32'd1 : 32'd2;
  endfunction

  // Registered output level for phase index c of a period of length n.
  function automatic logic phase_level(input int unsigned n, input int unsigned c);
    return (n >= 32'd2) && (c >= low_cycles(n));
  endfunction

  // True when a cycle ends the running period (idle and pass-through end every cycle).
  function automatic logic period_ends(input int unsigned n, input int unsigned c);
    return (n <= 32'd1) || (c == n - 32'd1);
  endfunction

endpackage

// File: rtl/baud_div_shadow.sv
module baud_div_shadow #(
  parameter int DIV_W = 16
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] value,
  input  logic             take,
  output logic [DIV_W-1:0] pend,
  output logic             pend_v
);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (load) begin
      pend   <= value;
      pend_v <= 1'b1;
    end else if (take) begin
      pend_v <= 1'b0;
    end
  end

  // R8: a consumed value leaves nothing pending.
  p_take_clears_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (take && !load) |=> !pend_v);

  // R8: a later load replaces whatever was pending.
  p_load_overwrites_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    load |=> (pend_v && pend == $past(value)));

endmodule

// File: rtl/baud_phase_counter.sv
module baud_phase_counter
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] pend,
  input  logic             pend_v,
  output logic [DIV_W-1:0] act,
  output logic [DIV_W-1:0] cnt,
  output logic             boundary,
  output logic             take,
  output logic [DIV_W-1:0] div_nxt,
  output logic [DIV_W-1:0] cnt_nxt
);

  always_comb begin
    boundary = period_ends(32'(act), 32'(cnt));
    take     = boundary && pend_v;
    div_nxt  = take ? pend : act;
    cnt_nxt  = boundary ? '0 : cnt + DIV_W'(1);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      cnt <= '0;
    end else begin
      act <= div_nxt;
      cnt <= cnt_nxt;
    end
  end

  // R3: phase index stays inside the running period.
  p_cnt_in_period_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act >= DIV_W'(2)) |-> (cnt < act));

  // R2: the running ratio only changes at a period boundary.
  p_ratio_held_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !boundary |=> (act == $past(act)));

endmodule

// File: rtl/baud_wave_shaper.sv
module baud_wave_shaper
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] act,
  input  logic [DIV_W-1:0] div_nxt,
  input  logic [DIV_W-1:0] cnt_nxt,
  output logic             baud_clk,
  output logic             baud_tick
);

  logic baud_q;
  logic tick_q;
  logic pass_ref;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      baud_q <= phase_level(32'(div_nxt), 32'(cnt_nxt));
      tick_q <= (div_nxt != '0) && (cnt_nxt == '0);
    end
  end

  assign pass_ref  = (act == DIV_W'(1));
  assign baud_clk  = pass_ref ? clk_ref : baud_q;
  assign baud_tick = tick_q;

  // R6: a tick always falls in the low phase of the registered waveform.
  p_tick_in_low_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tick_q |-> !baud_q);

endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_value,
  input  logic             div_load,
  output logic             baud_clk,
  output logic             baud_tick
);

  logic [DIV_W-1:0] pend;
  logic             pend_v;
  logic [DIV_W-1:0] act;
  logic [DIV_W-1:0] cnt;
  logic             boundary;
  logic             take;
  logic [DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0] cnt_nxt;

  baud_div_shadow #(.DIV_W(DIV_W)) u_shadow (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .load    (div_load),
    .value   (div_value),
    .take    (take),
    .pend    (pend),
    .pend_v  (pend_v)
  );

  baud_phase_counter #(.DIV_W(DIV_W)) u_counter (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .pend     (pend),
    .pend_v   (pend_v),
    .act      (act),
    .cnt      (cnt),
    .boundary (boundary),
    .take     (take),
    .div_nxt  (div_nxt),
    .cnt_nxt  (cnt_nxt)
  );

  baud_wave_shaper #(.DIV_W(DIV_W)) u_shaper (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .act       (act),
    .div_nxt   (div_nxt),
    .cnt_nxt   (cnt_nxt),
    .baud_clk  (baud_clk),
    .baud_tick (baud_tick)
  );

  // R7: a parked generator is silent.
  p_parked_quiet_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act == '0) |-> (!baud_tick && !baud_clk));

  // R3: the cycle after a tick is still low when N >= 3.
  p_low_two_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (baud_tick && act >= DIV_W'(3)) |=> (!baud_clk && !baud_tick));

  // R4: with N = 2 the output alternates every cycle.
  p_half_rate_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (baud_tick && act == DIV_W'(2) && !pend_v) |=> (baud_clk && !baud_tick));

endmodule

// File: tb/baud_clock_gen_test.sv
`timescale 1ns/1ps
module baud_clock_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_value = '0;
  logic        div_load = 1'b0;
  logic        baud_clk;
  logic        baud_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  baud_clock_gen uut (
    .clk_ref   (clk),
    .rst_n     (rst_n),
    .div_value (div_value),
    .div_load  (div_load),
    .baud_clk  (baud_clk),
    .baud_tick (baud_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int actv, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, actv, expv, $time);
    end
  endtask

  // Drive a one-cycle load; returns at the negedge after the capturing edge.
  task automatic load(input int v);
    div_value = 16'(v);
    div_load  = 1'b1;
    @(negedge clk);
    div_load  = 1'b0;
  endtask

  // Compare a run of cycles against the arithmetic shape of ratio n.
  task automatic expect_run(input int n, input int c0, input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      int c = (c0 + i) % n;
      int lowlen = (n == 2) ? 1 : 2;
      int eb = (c >= lowlen) ? 1 : 0;
      int et = (c == 0) ? 1 : 0;
      check(baud_clk == eb[0], req, $sformatf("baud_clk n=%0d phase=%0d", n, c), baud_clk, eb);
      check(baud_tick == et[0], "R6", $sformatf("baud_tick n=%0d phase=%0d", n, c), baud_tick, et);
      @(negedge clk);
    end
  endtask

  task automatic start(input int n);
    load(n);
    @(negedge clk);
  endtask

  task automatic park(input int prev);
    load(0);
    repeat (prev + 2) @(negedge clk);
    check(!baud_clk && !baud_tick, "R7", "parked outputs", {baud_clk, baud_tick}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: quiet during and after reset
    repeat (3) @(negedge clk);
    check(!baud_clk && !baud_tick, "R1", "outputs in reset", {baud_clk, baud_tick}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!baud_clk && !baud_tick, "R1", "outputs after reset", {baud_clk, baud_tick}, 0);
    end

    // R3 / R4: sweep of ratios from parked, three periods each
    for (int n = 2; n <= 40; n++) begin
      start(n);
      expect_run(n, 0, 3 * n, (n == 2) ? "R4" : "R3");
      park(n);
    end

    // R2: reload in mid period keeps the old period intact
    start(10);
    expect_run(10, 0, 3, "R2");
    load(4);
    expect_run(10, 4, 6, "R2");
    expect_run(4, 0, 12, "R2");
    park(4);

    // R8: two loads in one period, the later one applies
    start(10);
    div_value = 16'd5;
    div_load  = 1'b1;
    @(negedge clk);
    div_value = 16'd7;
    @(negedge clk);
    div_load  = 1'b0;
    expect_run(10, 2, 8, "R8");
    expect_run(7, 0, 14, "R8");

    // R7: ratio 0 parks after the current period
    load(0);
    expect_run(7, 1, 6, "R7");
    for (int i = 0; i < 20; i++) begin
      check(!baud_clk && !baud_tick, "R7", "idle after zero", {baud_clk, baud_tick}, 0);
      @(negedge clk);
    end

    // R5: ratio 1 follows the reference clock
    start(1);
    for (int i = 0; i < 8; i++) begin
      check(baud_clk == 1'b0, "R5", "baud_clk low half", baud_clk, 0);
      check(baud_tick == 1'b1, "R5", "tick held", baud_tick, 1);
      @(posedge clk);
      #1;
      check(baud_clk == 1'b1, "R5", "baud_clk high half", baud_clk, 1);
      check(baud_tick == 1'b1, "R5", "tick held high half", baud_tick, 1);
      @(negedge clk);
    end
    // R2: leaving ratio 1 starts the new ratio promptly
    start(5);
    expect_run(5, 0, 10, "R2");

    // R9: for N>=2 the output is steady between rising edges
    for (int i = 0; i < 10; i++) begin
      logic lvl = baud_clk;
      @(posedge clk);
      #1;
      lvl = baud_clk;
      #3;
      check(baud_clk == lvl, "R9", "baud_clk steady within cycle", baud_clk, lvl);
    end
    @(negedge clk);
    park(5);

    // R3: largest ratio, one full period and the next boundary
    start(65535);
    expect_run(65535, 0, 65537, "R3");

    finish_run();
  end

endmodule